// File: doc/BRIEF.md
# Supply Controller I2C Slave

This block is a two-wire serial slave placed in front of a supply regulator. It keeps two 5-bit control registers: a primary one that drives the regulator's controls, and an auxiliary one that is only stored and made available. It follows the bus with a two-flop synchronizer on each line and finds START, STOP and clock edges in the system clock domain. It takes an address byte, then accepts write bytes or returns status bytes. It acknowledges only while the supply's power-good input is high.

Every written data byte carries its own register-select bit, so one transfer can update either register. The primary register is decoded into an output level in volts, a tone output, a dynamic current-limit enable and a channel enable. A read returns the register chosen by the most recent write. The two low bits of each returned byte carry the live overload and overtemperature flags, and writes cannot change those flags.

Top module: `psu_i2c_ctl`

## Requirements
- R1: The slave address is the 7-bit value {5'b00010, addr_strap_i}. It is sent in bits 7..1 of the first byte after START, and bit 0 is the direction bit (1 = read, 0 = write). On a match the slave holds SDA low through the whole ninth clock.
- R2: While pwr_good_i is low the slave acknowledges neither an address byte nor a data byte, and a data byte it did not acknowledge leaves both registers unchanged.
- R3: After reset both registers are zero. That gives volts_o = 13, ch_en_o = 0, dyn_ilim_o = 0, tone_o equal to tone_pin_i, aux_o = 0 and SDA released.
- R4: In a written data byte, bit 7 selects the target (0 = primary, 1 = auxiliary) and bits 6..2 are stored as the 5-bit field word. aux_o shows the auxiliary word with byte bit 2 in aux_o[0].
- R5: Primary bit 6 (level high) and bit 5 (compensation) give the output level: 00 gives 13 V, 10 gives 18 V, 01 gives 14 V and 11 gives 19 V, shown on volts_o.
- R6: tone_o is 1 when primary bit 4 is set and follows tone_pin_i otherwise. dyn_ilim_o is primary bit 3 and ch_en_o is primary bit 2.
- R7: A write transfer may carry any number of data bytes. Each one is acknowledged and stored on its own.
- R8: A read byte is {select bit of the last stored write, that register's 5-bit word, overload_i, overtemp_i}, sent most significant bit first.
- R9: After a master ACK the slave sends the next byte. After a master NACK it stops driving SDA.
- R10: The two flag bits in a read byte always come from the live inputs. Bits 1..0 of a written byte have no effect.
- R11: A START or STOP in the middle of a byte abandons that byte without changing either register. The next transfer is handled normally.
- R12: The slave changes its SDA drive only after an SCL falling edge, a START or a STOP, never while SCL is high.
- R13: A non-matching address gets no acknowledge, and the rest of that transfer is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_low_o | output | 1 | 1 pulls the data line low (open-drain drive) |
| pwr_good_i | input | 1 | Supply power-good; low suppresses every acknowledge |
| addr_strap_i | input | 2 | Low two bits of the slave address |
| overload_i | input | 1 | Live overload flag, read-only |
| overtemp_i | input | 1 | Live overtemperature flag, read-only |
| tone_pin_i | input | 1 | External tone request |
| volts_o | output | 5 | Selected output level in volts |
| tone_o | output | 1 | Tone enable after forcing |
| dyn_ilim_o | output | 1 | Dynamic current-limit enable |
| ch_en_o | output | 1 | Channel enable |
| aux_o | output | 5 | Auxiliary register word |

## Verification
Seven write bytes drive the primary register through all four level codes, forced and unforced tone, current limit set and clear, and enable off with the flag bits set. This separates a swapped level pair, wrong field positions and a leak from the read-only bits. Directed transfers then target the auxiliary register, use a wrong strap address, drop power-good at the address and again at a data byte, send several bytes in one write and do reads with ACK then NACK. They show whether acknowledge gating, the select bit and the live flag merge each work on their own. Truncated bytes ended by a repeated START and by a STOP check that aborts leave the registers intact and that the engine recovers.

// File: rtl/psu_i2c_pkg.sv
package psu_i2c_pkg;

  localparam int BYTE_W    = 8;
  localparam int FIELD_W   = 5;
  localparam int CNT_W     = $clog2(BYTE_W + 1);
  localparam int ADDR_HI_W = 5;
  localparam int VOLT_W    = 5;

  // byte layout: [7] select, [6:2] field word, [1:0] flags (read only)
  localparam int SEL_BIT  = 7;
  localparam int FLD_LSB  = 2;

  // field word bit indexes
  localparam int F_EN   = 0;
  localparam int F_DYN  = 1;
  localparam int F_TONE = 2;
  localparam int F_COMP = 3;
  localparam int F_VSEL = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WR,
    ST_WACK,
    ST_RD,
    ST_MACK
  } eng_state_t;

  function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                    input logic [ADDR_HI_W-1:0] hi,
                                    input logic [1:0] strap);
    return b[BYTE_W-1:1] == {hi, strap};
  endfunction

  function automatic logic [VOLT_W-1:0] level_volts(input logic hi,
                                                    input logic comp);
    logic [VOLT_W-1:0] v;
    v = VOLT_W'(13);
    if (hi)   v = v + VOLT_W'(5);
    if (comp) v = v + VOLT_W'(1);
    return v;
  endfunction

  function automatic logic [BYTE_W-1:0] pack_status(input logic sel,
                                                    input logic [FIELD_W-1:0] fld,
                                                    input logic olf,
                                                    input logic otf);
    return {sel, fld, olf, otf};
  endfunction

endpackage

// File: rtl/psu_i2c_sync.sv
module psu_i2c_sync #(
  parameter int  W       = 2,
  parameter int  STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = chain[STAGES-1];
  end

endmodule

// File: rtl/psu_i2c_linecond.sv
module psu_i2c_linecond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic ev_start,
  output logic ev_stop,
  output logic ev_rise,
  output logic ev_fall
);

  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign ev_start = scl_s & scl_d & sda_d & ~sda_s;
  assign ev_stop  = scl_s & scl_d & ~sda_d & sda_s;
  assign ev_rise  = scl_s & ~scl_d;
  assign ev_fall  = ~scl_s & scl_d;

endmodule

// File: rtl/psu_i2c_engine.sv
module psu_i2c_engine
  import psu_i2c_pkg::*;
#(
  parameter logic [ADDR_HI_W-1:0] ADDR_HI = 5'b00010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_start,
  input  logic              ev_stop,
  input  logic              ev_rise,
  input  logic              ev_fall,
  input  logic              sda_s,
  input  logic              pwr_good,
  input  logic [1:0]        strap,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              sda_low,
  output logic              wr_commit,
  output logic [BYTE_W-1:0] wr_byte,
  output logic              ack_slot
);

  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

  eng_state_t        st;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh;
  logic [BYTE_W-1:0] tx;
  logic              rw;
  logic              mack;
  logic              byte_done;

  assign byte_done = ev_fall && (cnt == CNT_FULL);
  assign wr_commit = (st == ST_WR) && byte_done && pwr_good;
  assign wr_byte   = sh;
  assign ack_slot  = (st == ST_AACK) || (st == ST_WACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      sh      <= '0;
      tx      <= '0;
      rw      <= 1'b0;
      mack    <= 1'b0;
      sda_low <= 1'b0;
    end else if (ev_start) begin
      st      <= ST_ADDR;
      cnt     <= '0;
      sda_low <= 1'b0;
    end else if (ev_stop) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      sda_low <= 1'b0;
    end else begin
      unique case (st)
        ST_ADDR, ST_WR: begin
          if (ev_rise && cnt != CNT_FULL) begin
            sh  <= {sh[BYTE_W-2:0], sda_s};
            cnt <= cnt + 1'b1;
          end else if (byte_done) begin
            cnt <= '0;
            if (st == ST_ADDR) begin
              if (addr_hit(sh, ADDR_HI, strap) && pwr_good) begin
                st      <= ST_AACK;
                sda_low <= 1'b1;
                rw      <= sh[0];
              end else begin
                st <= ST_IDLE;
              end
            end else begin
              st      <= ST_WACK;
              sda_low <= pwr_good;
            end
          end
        end
        ST_AACK: begin
          if (ev_fall) begin
            cnt <= '0;
            if (rw) begin
              st      <= ST_RD;
              tx      <= rd_byte;
              sda_low <= ~rd_byte[BYTE_W-1];
            end else begin
              st      <= ST_WR;
              sda_low <= 1'b0;
            end
          end
        end
        ST_WACK: begin
          if (ev_fall) begin
            st      <= ST_WR;
            sda_low <= 1'b0;
          end
        end
        ST_RD: begin
          if (ev_rise) begin
            cnt <= cnt + 1'b1;
          end else if (ev_fall) begin
            if (cnt == CNT_FULL) begin
              st      <= ST_MACK;
              cnt     <= '0;
              sda_low <= 1'b0;
            end else begin
              tx      <= {tx[BYTE_W-2:0], 1'b0};
              sda_low <= ~tx[BYTE_W-2];
            end
          end
        end
        ST_MACK: begin
          if (ev_rise) begin
            mack <= ~sda_s;
          end else if (ev_fall) begin
            if (mack) begin
              st      <= ST_RD;
              tx      <= rd_byte;
              sda_low <= ~rd_byte[BYTE_W-1];
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/psu_i2c_regs.sv
module psu_i2c_regs
  import psu_i2c_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_commit,
  input  logic               wr_sel,
  input  logic [FIELD_W-1:0] wr_fld,
  output logic [FIELD_W-1:0] sr1_q,
  output logic [FIELD_W-1:0] sr2_q,
  output logic               rd_sel_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr1_q    <= '0;
      sr2_q    <= '0;
      rd_sel_q <= 1'b0;
    end else if (wr_commit) begin
      rd_sel_q <= wr_sel;
      if (wr_sel) sr2_q <= wr_fld;
      else        sr1_q <= wr_fld;
    end
  end

endmodule

// File: rtl/psu_i2c_ctl.sv
module psu_i2c_ctl
  import psu_i2c_pkg::*;
#(
  parameter logic [ADDR_HI_W-1:0] ADDR_HI = 5'b00010
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_low_o,
  input  logic               pwr_good_i,
  input  logic [1:0]         addr_strap_i,
  input  logic               overload_i,
  input  logic               overtemp_i,
  input  logic               tone_pin_i,
  output logic [VOLT_W-1:0]  volts_o,
  output logic               tone_o,
  output logic               dyn_ilim_o,
  output logic               ch_en_o,
  output logic [FIELD_W-1:0] aux_o
);

  logic               scl_s, sda_s;
  logic               ev_start, ev_stop, ev_rise, ev_fall;
  logic               wr_commit, ack_slot;
  logic [BYTE_W-1:0]  wr_byte, rd_byte;
  logic [FIELD_W-1:0] sr1_q, sr2_q;
  logic               rd_sel_q;

  psu_i2c_sync #(.W(2), .STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({scl_i, sda_i}),
    .q_o   ({scl_s, sda_s})
  );

  psu_i2c_linecond u_cond (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .ev_start (ev_start),
    .ev_stop  (ev_stop),
    .ev_rise  (ev_rise),
    .ev_fall  (ev_fall)
  );

  assign rd_byte = pack_status(rd_sel_q, rd_sel_q ? sr2_q : sr1_q,
                               overload_i, overtemp_i);

  psu_i2c_engine #(.ADDR_HI(ADDR_HI)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_start  (ev_start),
    .ev_stop   (ev_stop),
    .ev_rise   (ev_rise),
    .ev_fall   (ev_fall),
    .sda_s     (sda_s),
    .pwr_good  (pwr_good_i),
    .strap     (addr_strap_i),
    .rd_byte   (rd_byte),
    .sda_low   (sda_low_o),
    .wr_commit (wr_commit),
    .wr_byte   (wr_byte),
    .ack_slot  (ack_slot)
  );

  psu_i2c_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_commit (wr_commit),
    .wr_sel    (wr_byte[SEL_BIT]),
    .wr_fld    (wr_byte[FLD_LSB +: FIELD_W]),
    .sr1_q     (sr1_q),
    .sr2_q     (sr2_q),
    .rd_sel_q  (rd_sel_q)
  );

  logic unused_lsbs;
  assign unused_lsbs = ^wr_byte[FLD_LSB-1:0];

  assign volts_o    = level_volts(sr1_q[F_VSEL], sr1_q[F_COMP]);
  assign tone_o     = sr1_q[F_TONE] | tone_pin_i;
  assign dyn_ilim_o = sr1_q[F_DYN];
  assign ch_en_o    = sr1_q[F_EN];
  assign aux_o      = sr2_q;

endmodule

// File: rtl/psu_i2c_ctl_chk.sv
module psu_i2c_ctl_chk
  import psu_i2c_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               ev_fall,
  input logic               ev_start,
  input logic               ev_stop,
  input logic               sda_low_o,
  input logic               wr_commit,
  input logic               ack_slot,
  input logic               pwr_good_i,
  input logic [FIELD_W-1:0] sr1_q,
  input logic [FIELD_W-1:0] sr2_q
);

  AST_SDA_ON_LOW_SCL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_low_o) |-> $past(ev_fall || ev_start || ev_stop)); // R12

  AST_ACK_NEEDS_PG: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_low_o) && ack_slot) |-> $past(pwr_good_i)); // R2

  AST_COMMIT_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> (sda_low_o && ack_slot)); // R7

  AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_commit |=> ($stable(sr1_q) && $stable(sr2_q))); // R11

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> !sda_low_o); // R9

endmodule

bind psu_i2c_ctl psu_i2c_ctl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ev_fall    (ev_fall),
  .ev_start   (ev_start),
  .ev_stop    (ev_stop),
  .sda_low_o  (sda_low_o),
  .wr_commit  (wr_commit),
  .ack_slot   (ack_slot),
  .pwr_good_i (pwr_good_i),
  .sr1_q      (sr1_q),
  .sr2_q      (sr2_q)
);

// File: tb/psu_i2c_ctl_tb.sv
`timescale 1ns/1ps
module psu_i2c_ctl_tb;

  localparam int Q = 16;
  localparam logic [7:0] AW = 8'h14;  // {00010,10,0}
  localparam logic [7:0] AR = 8'h15;

  // {data byte, volts, tone_force, dyn, en}
  localparam logic [15:0] VEC [7] = '{
    {8'h04, 5'd13, 3'b001},
    {8'h44, 5'd18, 3'b001},
    {8'h24, 5'd14, 3'b001},
    {8'h64, 5'd19, 3'b001},
    {8'h1C, 5'd13, 3'b111},
    {8'h00, 5'd13, 3'b000},
    {8'h6B, 5'd19, 3'b010}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic pg = 1'b1;
  logic [1:0] strap = 2'b10;
  logic olf = 1'b0, otf = 1'b0, tpin = 1'b0;
  logic sda_low;
  logic sda_bus;
  logic [4:0] volts, aux;
  logic tone, dyn, en;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  assign sda_bus = !(m_low || sda_low);

  psu_i2c_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_low_o(sda_low),
    .pwr_good_i(pg), .addr_strap_i(strap), .overload_i(olf), .overtemp_i(otf),
    .tone_pin_i(tpin), .volts_o(volts), .tone_o(tone), .dyn_ilim_o(dyn),
    .ch_en_o(en), .aux_o(aux)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_low = 1'b0; w(Q); scl = 1'b1; w(Q); m_low = 1'b1; w(Q); scl = 1'b0; w(Q);
  endtask

  task automatic i2c_stop();
    m_low = 1'b1; w(Q); scl = 1'b1; w(Q); m_low = 1'b0; w(Q);
  endtask

  task automatic send_bit(input logic b);
    m_low = !b; w(Q); scl = 1'b1; w(Q); scl = 1'b0;
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_low = 1'b0; w(Q); scl = 1'b1; w(Q/2); ack = !sda_bus; w(Q/2); scl = 1'b0;
  endtask

  task automatic rd_byte(input logic master_ack, output logic [7:0] b);
    logic s1;
    for (int i = 7; i >= 0; i--) begin
      m_low = 1'b0; w(Q); scl = 1'b1; w(Q/2); s1 = sda_bus; b[i] = s1;
      w(Q/2 - 1);
      chk("R12 sda stable while scl high", sda_bus, s1);
      w(1); scl = 1'b0;
    end
    m_low = master_ack; w(Q); scl = 1'b1; w(Q); scl = 1'b0;
  endtask

  task automatic write1(input logic [7:0] a, input logic [7:0] d,
                        output logic aa, output logic ad);
    i2c_start(); wr_byte(a, aa); wr_byte(d, ad); i2c_stop();
  endtask

  initial begin
    logic aa, ad;
    logic [7:0] rb;
    w(4); rst_n = 1'b1; w(4);
    // R3 reset state
    chk("R3 volts", volts, 13);
    chk("R3 en", en, 0);
    chk("R3 dyn", dyn, 0);
    chk("R3 tone follows pin", tone, 0);
    chk("R3 aux", aux, 0);
    chk("R3 sda released", sda_low, 0);

    // table: R1 R4 R5 R6
    foreach (VEC[i]) begin
      write1(AW, VEC[i][15:8], aa, ad);
      chk("R1 address ack", aa, 1);
      chk("R4 data ack", ad, 1);
      chk("R5 volts", volts, VEC[i][7:3]);
      chk("R6 tone", tone, VEC[i][2]);
      chk("R6 dyn", dyn, VEC[i][1]);
      chk("R6 en", en, VEC[i][0]);
    end

    // R6 tone pin passthrough while not forced
    tpin = 1'b1; w(2);
    chk("R6 tone follows pin high", tone, 1);
    tpin = 1'b0;
    write1(AW, 8'h44, aa, ad);
    chk("R5 18V", volts, 18);

    // R13 wrong strap address
    write1(8'h16, 8'h00, aa, ad);
    chk("R13 no address ack", aa, 0);
    chk("R13 data ignored en", en, 1);

    // R2 power-good low at address
    pg = 1'b0;
    write1(AW, 8'h00, aa, ad);
    chk("R2 no address ack pg low", aa, 0);
    chk("R2 en kept", en, 1);
    // R2 power-good drops before data byte
    pg = 1'b1;
    i2c_start(); wr_byte(AW, aa);
    chk("R2 address ack pg high", aa, 1);
    pg = 1'b0;
    wr_byte(8'h00, ad); i2c_stop();
    pg = 1'b1;
    chk("R2 no data ack pg low", ad, 0);
    chk("R2 en not written", en, 1);

    // R4 auxiliary register via select bit
    write1(AW, 8'hAC, aa, ad);
    chk("R4 aux word", aux, 5'b01011);
    chk("R4 primary untouched", volts, 18);

    // R8 R9 read two bytes, ACK then NACK
    olf = 1'b1; otf = 1'b0;
    i2c_start(); wr_byte(AR, aa);
    chk("R1 read address ack", aa, 1);
    rd_byte(1'b1, rb);
    chk("R8 first read byte", rb, 8'hAE);
    rd_byte(1'b0, rb);
    chk("R9 second byte after ACK", rb, 8'hAE);
    w(8);
    chk("R9 released after NACK", sda_low, 0);
    i2c_stop();

    // R10 live flags
    olf = 1'b0; otf = 1'b1;
    i2c_start(); wr_byte(AR, aa); rd_byte(1'b0, rb); i2c_stop();
    chk("R10 live flags", rb, 8'hAD);

    // R10 written flag bits have no effect
    olf = 1'b0; otf = 1'b0;
    write1(AW, 8'h47, aa, ad);
    i2c_start(); wr_byte(AR, aa); rd_byte(1'b0, rb); i2c_stop();
    chk("R10 flags not writable", rb, 8'h44);

    // R7 several bytes in one write
    i2c_start(); wr_byte(AW, aa);
    wr_byte(8'h04, ad); chk("R7 byte1 ack", ad, 1);
    wr_byte(8'h64, ad); chk("R7 byte2 ack", ad, 1);
    chk("R7 byte2 stored", volts, 19);
    wr_byte(8'h24, ad); chk("R7 byte3 ack", ad, 1);
    i2c_stop();
    chk("R7 last byte stored", volts, 14);

    // R11 repeated START mid data byte
    i2c_start(); wr_byte(AW, aa);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    i2c_start(); i2c_stop();
    chk("R11 volts kept after restart", volts, 14);
    chk("R11 en kept after restart", en, 1);
    // R11 STOP mid address byte, then normal write
    i2c_start(); send_bit(1'b0); send_bit(1'b0); send_bit(1'b0); i2c_stop();
    write1(AW, 8'h44, aa, ad);
    chk("R11 recovered ack", ad, 1);
    chk("R11 recovered write", volts, 18);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule